// File: doc/BRIEF.md
# Panel Scan Timing Generator

This block turns a pixel-rate clock and an optional frame sync into the digital drive signals of a stripe-type active-matrix panel. The panel has its own horizontal and vertical shift registers, so the block does not deliver pixel data. It delivers the pulses that walk those registers across the glass. It produces the following signals:

- a complementary pair of horizontal shift clocks;
- a pre-charge start pulse and the horizontal start pulse that follows it;
- a vertical start pulse and a vertical shift clock;
- a gate enable pulse placed in horizontal blanking;
- the two scan-direction levels.

Every duration is a parameter counted in pixel clocks or in horizontal clock periods.

Two counters set the position. A line counter steps through `LINE_HCLKS` horizontal clock periods per line, and a frame counter steps through `FRAME_LINES` lines. Line 0 is the dummy line that comes before the first gate line. Lines 1 to `ACTIVE_LINES` are the gate lines, and the remaining lines are vertical blanking. The direction inputs are taken only when a frame starts, so a mode change always lands on a frame boundary. Below, "count" is the position inside the line. Count 0 is the first cycle after a line or frame start edge, and HP = 2·`HCLK_HALF`.

Top module: `panel_scan_timer`

## Requirements
- R1: `rst` is synchronous and active high. In every cycle that follows a clock edge with `rst` high, all nine outputs are 0. The first edge with `rst` low starts a frame at line 0, count 0, and samples the direction inputs.
- R2: After reset, `hclk_a` and `hclk_b` are always complementary. In right scan (`dir_right`=1), `hclk_a` is high while count mod HP < `HCLK_HALF`. In left scan the two outputs swap.
- R3: On lines 0..`ACTIVE_LINES`, `pre_start` is high for counts `PRE_OFF` to `PRE_OFF+PRE_W-1`.
- R4: On the same lines, `hstart` is high for `HSTART_W` counts starting at count HS = `PRE_OFF`+4·HP. It therefore rises exactly 4 horizontal clock periods after `pre_start`, together with a rise of `hclk_a` in right scan or of `hclk_b` in left scan.
- R5: The video period ends at count VE = HS + `VIDEO_HCLKS`·HP. On lines 0..`ACTIVE_LINES`, `gate_en` is high for `GATE_W` counts starting at VE+`GATE_DLY`, and `vclk` does not change while `gate_en` is high.
- R6: `vclk` = (line index odd) XOR (count ≥ VE+`VCLK_DLY`). The clock therefore makes one edge per line, and it is low at the start of a frame.
- R7: `vstart` is high only on line 0, for counts 0 to VE+`VCLK_DLY`+`VSTART_HOLD`-1. It covers the rising `vclk` edge of that line, with setup and hold on both sides.
- R8: On the blanking lines (`ACTIVE_LINES`+1 .. `FRAME_LINES`-1), `pre_start`, `hstart` and `gate_en` stay low.
- R9: `dir_right` and `dir_down` show the levels of `right_in` and `down_in` as sampled at the last frame start. A change of these inputs in the middle of a frame has no effect on any output until the next frame start.
- R10: A clock edge with `frame_sync` high restarts the frame at line 0, count 0, and samples the direction inputs.
- R11: With no `frame_sync`, the frame wraps to line 0, count 0 after count `LINE_HCLKS`·HP-1 of line `FRAME_LINES`-1, and the direction inputs are sampled there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Restarts the frame at the dummy line |
| right_in | input | 1 | Horizontal direction request, 1 = scan to the right |
| down_in | input | 1 | Vertical direction request, 1 = scan downward |
| hclk_a | output | 1 | Horizontal shift clock, first phase |
| hclk_b | output | 1 | Horizontal shift clock, complementary phase |
| hstart | output | 1 | Horizontal start pulse |
| pre_start | output | 1 | Pre-charge start pulse |
| vstart | output | 1 | Vertical start pulse |
| vclk | output | 1 | Vertical shift clock |
| gate_en | output | 1 | Gate enable pulse |
| dir_right | output | 1 | Horizontal direction in force for this frame |
| dir_down | output | 1 | Vertical direction in force for this frame |

## Verification
A reference model in the bench predicts all nine outputs for every cycle. Several input patterns are used, and each one tells apart a different kind of fault:

- **Undisturbed frames in right/down mode** check the position of every pulse and the blanking lines.
- **A direction change requested mid-frame** separates sampling at the frame boundary from immediate pass-through, and the left scan that follows exposes a wrong clock phase.
- **A frame sync pulse mid-frame** separates a true restart from a simple counter wrap.
- **A second reset in the middle of a run** checks that every output goes idle and that scanning resumes from the dummy line.

// File: rtl/panel_scan_timer.sv
module panel_scan_timer #(
  parameter int HCLK_HALF    = 2,
  parameter int LINE_HCLKS   = 260,
  parameter int VIDEO_HCLKS  = 228,
  parameter int PRE_OFF      = 8,
  parameter int PRE_W        = 4,
  parameter int HSTART_W     = 4,
  parameter int VCLK_DLY     = 4,
  parameter int GATE_DLY     = 8,
  parameter int GATE_W       = 27,
  parameter int VSTART_HOLD  = 8,
  parameter int ACTIVE_LINES = 768,
  parameter int FRAME_LINES  = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync,
  input  logic right_in,
  input  logic down_in,
  output logic hclk_a,
  output logic hclk_b,
  output logic hstart,
  output logic pre_start,
  output logic vstart,
  output logic vclk,
  output logic gate_en,
  output logic dir_right,
  output logic dir_down
);
  localparam int HP         = 2 * HCLK_HALF;
  localparam int LINE_CLKS  = LINE_HCLKS * HP;
  localparam int HS_AT      = PRE_OFF + 4 * HP;
  localparam int VID_END    = HS_AT + VIDEO_HCLKS * HP;
  localparam int VCLK_AT    = VID_END + VCLK_DLY;
  localparam int GATE_AT    = VID_END + GATE_DLY;
  localparam int HW         = $clog2(LINE_CLKS + 1);
  localparam int VW         = $clog2(FRAME_LINES + 1);
  localparam int PW         = $clog2(HP);

  localparam logic [HW-1:0] H_LAST   = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] PRE_LO   = HW'(PRE_OFF);
  localparam logic [HW-1:0] PRE_HI   = HW'(PRE_OFF + PRE_W);
  localparam logic [HW-1:0] HS_LO    = HW'(HS_AT);
  localparam logic [HW-1:0] HS_HI    = HW'(HS_AT + HSTART_W);
  localparam logic [HW-1:0] VC_EDGE  = HW'(VCLK_AT);
  localparam logic [HW-1:0] VS_END   = HW'(VCLK_AT + VSTART_HOLD);
  localparam logic [HW-1:0] GT_LO    = HW'(GATE_AT);
  localparam logic [HW-1:0] GT_HI    = HW'(GATE_AT + GATE_W);
  localparam logic [VW-1:0] V_LAST   = VW'(FRAME_LINES - 1);
  localparam logic [VW-1:0] V_DRIVE  = VW'(ACTIVE_LINES);
  localparam logic [PW-1:0] PH_LAST  = PW'(HP - 1);
  localparam logic [PW-1:0] PH_HALF  = PW'(HCLK_HALF);

  logic          live, right_q, down_q;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [PW-1:0] ph;
  logic          frame_end, restart, drive_line, phase_hi;

  assign frame_end = (hcnt == H_LAST) && (vcnt == V_LAST);
  assign restart   = !live || frame_sync || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      ph      <= '0;
      right_q <= 1'b0;
      down_q  <= 1'b0;
    end else if (restart) begin
      live    <= 1'b1;
      hcnt    <= '0;
      vcnt    <= '0;
      ph      <= '0;
      right_q <= right_in;
      down_q  <= down_in;
    end else begin
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      if (hcnt == H_LAST) begin
        hcnt <= '0;
        vcnt <= vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign drive_line = vcnt <= V_DRIVE;
  assign phase_hi   = (ph < PH_HALF) ~^ right_q;

  assign hclk_a    = live &  phase_hi;
  assign hclk_b    = live & ~phase_hi;
  assign pre_start = live & drive_line & (hcnt >= PRE_LO) & (hcnt < PRE_HI);
  assign hstart    = live & drive_line & (hcnt >= HS_LO)  & (hcnt < HS_HI);
  assign gate_en   = live & drive_line & (hcnt >= GT_LO)  & (hcnt < GT_HI);
  assign vclk      = live & (vcnt[0] ^ (hcnt >= VC_EDGE));
  assign vstart    = live & (vcnt == '0) & (hcnt < VS_END);
  assign dir_right = right_q;
  assign dir_down  = down_q;
endmodule

// File: rtl/panel_scan_timer_chk.sv
module panel_scan_timer_chk #(
  parameter int HCLK_HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic hclk_a,
  input logic hclk_b,
  input logic hstart,
  input logic pre_start,
  input logic vstart,
  input logic vclk,
  input logic gate_en,
  input logic dir_right,
  input logic dir_down
);
  localparam int unsigned LEAD  = 4 * 2 * HCLK_HALF;
  localparam int unsigned LIMIT = LEAD + 2;

  logic        rst_q, pre_q;
  int unsigned since_pre;

  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q     <= 1'b0;
      since_pre <= 0;
    end else begin
      pre_q <= pre_start;
      if (pre_start && !pre_q) since_pre <= 1;
      else if (since_pre < LIMIT) since_pre <= since_pre + 1;
    end
  end

  always @(negedge clk)
    if (rst_q === 1'b1)
      a_r1_idle_in_reset: assert ({hclk_a, hclk_b, hstart, pre_start, vstart,
                                   vclk, gate_en, dir_right, dir_down} == 9'd0);

  a_r2_complement: assert property (@(posedge clk) disable iff (rst)
    (hclk_a || hclk_b) |-> (hclk_a != hclk_b));

  a_r4_pre_lead: assert property (@(posedge clk) disable iff (rst)
    $rose(hstart) |-> (since_pre == LEAD));

  a_r4_clock_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(hstart) |-> (dir_right ? $rose(hclk_a) : $rose(hclk_b)));

  a_r5_vclk_quiet: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> $stable(vclk));

  a_r7_vstart_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(vstart) |-> !vclk);

  a_r7_vstart_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(vstart) |-> vclk);

  a_r9_right_at_frame: assert property (@(posedge clk) disable iff (rst)
    (dir_right != $past(dir_right)) |-> vstart);

  a_r9_down_at_frame: assert property (@(posedge clk) disable iff (rst)
    (dir_down != $past(dir_down)) |-> vstart);
endmodule

bind panel_scan_timer panel_scan_timer_chk #(.HCLK_HALF(HCLK_HALF)) u_chk (
  .clk(clk), .rst(rst), .hclk_a(hclk_a), .hclk_b(hclk_b), .hstart(hstart),
  .pre_start(pre_start), .vstart(vstart), .vclk(vclk), .gate_en(gate_en),
  .dir_right(dir_right), .dir_down(dir_down)
);

// File: tb/panel_scan_timer_test.sv
`timescale 1ns/1ps
module panel_scan_timer_test;
  localparam int HALF = 2, LHC = 20, VID = 8, POFF = 4, PW = 4, HSW = 4;
  localparam int VDLY = 2, GDLY = 6, GW = 10, VHOLD = 4, ACT = 5, FL = 8;
  localparam int HP = 2 * HALF, LC = LHC * HP;
  localparam int HS = POFF + 4 * HP, VE = HS + VID * HP;
  localparam int VAT = VE + VDLY, GAT = VE + GDLY;

  logic clk = 1'b0, rst = 1'b1, frame_sync = 1'b0, right_in = 1'b1, down_in = 1'b1;
  logic hclk_a, hclk_b, hstart, pre_start, vstart, vclk, gate_en, dir_right, dir_down;

  panel_scan_timer #(
    .HCLK_HALF(HALF), .LINE_HCLKS(LHC), .VIDEO_HCLKS(VID), .PRE_OFF(POFF),
    .PRE_W(PW), .HSTART_W(HSW), .VCLK_DLY(VDLY), .GATE_DLY(GDLY), .GATE_W(GW),
    .VSTART_HOLD(VHOLD), .ACTIVE_LINES(ACT), .FRAME_LINES(FL)
  ) uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] qv[$];
  string qc[$];
  string nm[9] = '{"dir_down", "dir_right", "gate_en", "vclk", "vstart",
                   "pre_start", "hstart", "hclk_b", "hclk_a"};
  string tg[9] = '{"R9", "R9", "R5", "R6", "R7", "R3", "R4", "R2", "R2"};

  bit ml = 0, mr = 0, md = 0;
  int mh = 0, mv = 0, ctx_n = 0;
  string ctx_t = "";

  task automatic tick();
    logic [8:0] e;
    bit hi, dl;
    string c;
    @(posedge clk);
    if (rst) begin
      ml = 0; mh = 0; mv = 0; mr = 0; md = 0; ctx_t = "R1"; ctx_n = 2;
    end else if (!ml || frame_sync || (mh == LC - 1 && mv == FL - 1)) begin
      ctx_t = frame_sync ? "R10" : (ml ? "R11" : "R1");
      ctx_n = 2 * HP;
      ml = 1; mh = 0; mv = 0; mr = right_in; md = down_in;
    end else if (mh == LC - 1) begin
      mh = 0; mv++;
    end else mh++;
    hi = ((mh % HP) < HALF) == mr;
    dl = mv <= ACT;
    e[8] = ml && hi;
    e[7] = ml && !hi;
    e[6] = ml && dl && mh >= HS && mh < HS + HSW;
    e[5] = ml && dl && mh >= POFF && mh < POFF + PW;
    e[4] = ml && mv == 0 && mh < VAT + VHOLD;
    e[3] = ml && ((mv % 2 == 1) != (mh >= VAT));
    e[2] = ml && dl && mh >= GAT && mh < GAT + GW;
    e[1] = mr;
    e[0] = md;
    if (ctx_n > 0) begin c = ctx_t; ctx_n--; end
    else if (!dl) c = "R8";
    else c = "";
    qv.push_back(e);
    qc.push_back(c);
    #1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(negedge clk) begin
    if (qv.size() > 0) begin
      logic [8:0] e, g;
      string c, t;
      e = qv.pop_front();
      c = qc.pop_front();
      g = {hclk_a, hclk_b, hstart, pre_start, vstart, vclk, gate_en, dir_right, dir_down};
      for (int i = 0; i < 9; i++) begin
        checks++;
        t = (c != "" && !(c == "R8" && i < 2) && !(c == "R8" && i > 6)) ? c : tg[i];
        if (g[i] !== e[i]) begin
          errors++;
          $display("FAIL %s %s got %b expected %b at %0t", t, nm[i], g[i], e[i], $time);
        end
      end
    end
  end

  initial begin
    run(3);                                    // R1 idle outputs
    rst = 1'b0;
    run(LC * FL + 100);                        // R3 R4 R5 R6 R7 R8 R11 right/down
    right_in = 1'b0; down_in = 1'b0;           // R9 mid-frame change ignored
    run(LC * 3);
    run(LC * FL);                              // R2 left scan after wrap
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;   // R10 restart
    run(LC * 2 + 13);
    right_in = 1'b1;
    frame_sync = 1'b1; tick(); frame_sync = 1'b0;   // R10 with new direction
    run(LC * FL + 7);
    rst = 1'b1; run(2); rst = 1'b0;            // R1 reset mid-run
    run(LC * 2);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule